// File: doc/BRIEF.md
# Chip-Select Resolver with Online Spare Substitution

This block decides which memory rank answers a normalized DRAM input address. It holds a table of chip-select entries. Each entry has a base, a mask and an enable bit. A mask bit of 1 marks an address bit as "don't care". For each request the block finds the lowest-numbered enabled entry whose compared bits agree with the address.

After a hit, the block applies online-spare substitution. A bad-rank number and a spare-rank number are held in a small configuration register. When the hit lands on the bad rank, the result is rerouted to the spare rank. The spare entry's own base, mask and enable are not consulted for this reroute. If the spare number names no existing entry, the reroute cannot happen. The original hit is then reported together with an error flag.

Software-side logic loads the table through a one-entry-per-cycle write port and sets the bad/spare pair through a second write strobe. Requests arrive with a valid strobe, and results come back registered one clock later.

Top module: `cs_resolver`

## Requirements
- R1: An enabled entry matches when every address bit whose mask bit is 0 equals the corresponding base bit. Mask bits of 1 are ignored in the comparison, so a mask of all zeros demands an exact match.
- R2: An entry whose enable bit is 0 never matches, whatever its base and mask.
- R3: When several enabled entries match, the lowest entry index is reported.
- R4: When no entry matches, the response has rsp_hit=0, rsp_cs equal to the invalid code (all ones of the index width), rsp_redirected=0 and rsp_redir_err=0.
- R5: When the matched index equals the bad-rank number and the spare number is below NUM_CS, the response carries rsp_cs = spare number, rsp_hit=1, rsp_redirected=1 and rsp_redir_err=0.
- R6: Redirection happens only when the matched index equals the bad-rank number. In particular, with the bad number equal to the invalid code (the reset value of both numbers), results are never redirected.
- R7: When the matched index equals the bad number but the spare number is not below NUM_CS, the response carries rsp_hit=1, rsp_cs = the matched index, rsp_redirected=0 and rsp_redir_err=1.
- R8: rsp_valid equals req_valid of the previous cycle. When rsp_valid is 0, rsp_hit, rsp_redirected and rsp_redir_err are 0 and rsp_cs holds the invalid code.
- R9: Reset clears every enable bit, sets the bad and spare numbers to the invalid code, and leaves rsp_valid=0 and rsp_cs at the invalid code.
- R10: A table write replaces base, mask and enable of entry ent_idx. A write to an index not below NUM_CS changes nothing. A request presented in the same cycle as a write is resolved against the table as it was before that write.
- R11: A spare write loads both the bad and the spare number. A request in the same cycle uses the previous pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_we | input | 1 | Table entry write strobe |
| ent_idx | input | IDX_W | Entry to write |
| ent_base | input | ADDR_W | Base value for the entry |
| ent_mask | input | ADDR_W | Don't-care mask for the entry (1 = ignore bit) |
| ent_on | input | 1 | Enable bit for the entry |
| spr_we | input | 1 | Bad/spare pair write strobe |
| spr_bad | input | IDX_W | Bad-rank number |
| spr_target | input | IDX_W | Spare-rank number |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Normalized input address |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_hit | output | 1 | An enabled entry matched |
| rsp_cs | output | IDX_W | Resolved chip-select index, invalid code on a miss |
| rsp_redirected | output | 1 | Result was rerouted to the spare rank |
| rsp_redir_err | output | 1 | Reroute requested but the spare number names no entry |

## Verification
The bench builds the block with NUM_CS=5 and ADDR_W=16, which gives a 3-bit index. With that setting the codes 5 and 6 are out-of-range spare numbers distinct from the invalid code 7. Writes to indices 5 to 7 are therefore possible and must leave the table untouched. The bench also selects the isolate-lowest-bit search variant, so overlapping entries exercise that priority path. A 16-bit address keeps the random requests dense enough to hit masked and exact-match entries often, alongside the directed corner cases.

// File: rtl/cs_resolver_pkg.sv
package cs_resolver_pkg;

   // Priority search implementation choice.
   typedef enum logic {
      SEARCH_SCAN    = 1'b0,  // descending loop, last assignment wins
      SEARCH_ISOLATE = 1'b1   // isolate lowest set bit, then OR-encode
   } search_style_e;

   // Index width able to hold every entry number plus a distinct invalid code.
   function automatic int idx_width(input int n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/cs_entry_bank.sv
module cs_entry_bank #(
   parameter int NUM_CS = 8,
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [IDX_W-1:0]                wr_idx,
   input  logic [ADDR_W-1:0]               wr_base,
   input  logic [ADDR_W-1:0]               wr_mask,
   input  logic                            wr_on,
   output logic [NUM_CS-1:0][ADDR_W-1:0]   base_o,
   output logic [NUM_CS-1:0][ADDR_W-1:0]   mask_o,
   output logic [NUM_CS-1:0]               en_o
);

   for (genvar g = 0; g < NUM_CS; g++) begin : g_ent
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
      logic sel;
      assign sel = wr_en && (wr_idx == MY_IDX);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_o[g] <= '0;
            mask_o[g] <= '0;
            en_o[g]   <= 1'b0;
         end else if (sel) begin
            base_o[g] <= wr_base;
            mask_o[g] <= wr_mask;
            en_o[g]   <= wr_on;
         end
      end
   end

endmodule

// File: rtl/cs_compare.sv
module cs_compare #(
   parameter int NUM_CS = 8,
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]               addr,
   input  logic [NUM_CS-1:0][ADDR_W-1:0]   base,
   input  logic [NUM_CS-1:0][ADDR_W-1:0]   mask,
   input  logic [NUM_CS-1:0]               en,
   output logic [NUM_CS-1:0]               hit_vec
);

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
      logic [ADDR_W-1:0] care;
      assign care       = ~mask[g];
      assign hit_vec[g] = en[g] && ((addr & care) == (base[g] & care));
   end

endmodule

// File: rtl/cs_first_hit.sv
module cs_first_hit
   import cs_resolver_pkg::*;
#(
   parameter int            NUM_CS = 8,
   parameter int            IDX_W  = 4,
   parameter search_style_e STYLE  = SEARCH_SCAN
) (
   input  logic [NUM_CS-1:0] hit_vec,
   output logic              any_o,
   output logic [IDX_W-1:0]  idx_o
);

   localparam logic [IDX_W-1:0] INV_IDX = '1;

   if (STYLE == SEARCH_SCAN) begin : g_scan
      always_comb begin
         any_o = 1'b0;
         idx_o = INV_IDX;
         for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
               any_o = 1'b1;
               idx_o = IDX_W'(i);
            end
         end
      end
   end else begin : g_isolate
      localparam logic [NUM_CS-1:0] ONE = NUM_CS'(1);
      logic [NUM_CS-1:0] lowest;
      logic [IDX_W-1:0]  enc;

      assign lowest = hit_vec & (~hit_vec + ONE);

      always_comb begin
         enc = '0;
         for (int i = 0; i < NUM_CS; i++) begin
            if (lowest[i]) enc = enc | IDX_W'(i);
         end
      end

      assign any_o = |hit_vec;
      assign idx_o = any_o ? enc : INV_IDX;
   end

endmodule

// File: rtl/cs_spare_map.sv
module cs_spare_map #(
   parameter int NUM_CS = 8,
   parameter int IDX_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [IDX_W-1:0] cfg_bad,
   input  logic [IDX_W-1:0] cfg_target,
   input  logic             hit_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [IDX_W-1:0] bad_q,
   output logic [IDX_W-1:0] tgt_q,
   output logic [IDX_W-1:0] cs_o,
   output logic             moved_o,
   output logic             fail_o
);

   localparam logic [IDX_W-1:0] INV_IDX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bad_q <= INV_IDX;
         tgt_q <= INV_IDX;
      end else if (cfg_we) begin
         bad_q <= cfg_bad;
         tgt_q <= cfg_target;
      end
   end

   logic wants_move;
   logic tgt_exists;

   always_comb begin
      wants_move = hit_i && (idx_i == bad_q);
      tgt_exists = int'(tgt_q) < NUM_CS;
      moved_o    = wants_move && tgt_exists;
      fail_o     = wants_move && !tgt_exists;
      cs_o       = moved_o ? tgt_q : idx_i;
   end

endmodule

// File: rtl/cs_resolver.sv
module cs_resolver
   import cs_resolver_pkg::*;
#(
   parameter int            NUM_CS = 8,
   parameter int            ADDR_W = 32,
   parameter int            IDX_W  = cs_resolver_pkg::idx_width(NUM_CS),
   parameter search_style_e STYLE  = SEARCH_SCAN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ent_we,
   input  logic [IDX_W-1:0]  ent_idx,
   input  logic [ADDR_W-1:0] ent_base,
   input  logic [ADDR_W-1:0] ent_mask,
   input  logic              ent_on,
   input  logic              spr_we,
   input  logic [IDX_W-1:0]  spr_bad,
   input  logic [IDX_W-1:0]  spr_target,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [IDX_W-1:0]  rsp_cs,
   output logic              rsp_redirected,
   output logic              rsp_redir_err
);

   localparam logic [IDX_W-1:0] INV_IDX = '1;

   // Elaboration-time parameter checks.
   if (NUM_CS < 1) begin : g_chk_num
      $error("cs_resolver: NUM_CS must be at least 1");
   end
   if (ADDR_W < 1) begin : g_chk_addr
      $error("cs_resolver: ADDR_W must be at least 1");
   end
   if (IDX_W < $clog2(NUM_CS + 1)) begin : g_chk_idx
      $error("cs_resolver: IDX_W too narrow to keep an invalid code apart");
   end

   logic [NUM_CS-1:0][ADDR_W-1:0] tbl_base;
   logic [NUM_CS-1:0][ADDR_W-1:0] tbl_mask;
   logic [NUM_CS-1:0]             en_vec;
   logic [NUM_CS-1:0]             hit_vec;
   logic                          any_hit;
   logic [IDX_W-1:0]              first_idx;
   logic [IDX_W-1:0]              spr_bad_q;
   logic [IDX_W-1:0]              spr_tgt_q;
   logic [IDX_W-1:0]              final_cs;
   logic                          moved;
   logic                          move_fail;

   cs_entry_bank #(
      .NUM_CS (NUM_CS),
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ent_we),
      .wr_idx  (ent_idx),
      .wr_base (ent_base),
      .wr_mask (ent_mask),
      .wr_on   (ent_on),
      .base_o  (tbl_base),
      .mask_o  (tbl_mask),
      .en_o    (en_vec)
   );

   cs_compare #(
      .NUM_CS (NUM_CS),
      .ADDR_W (ADDR_W)
   ) u_cmp (
      .addr    (req_addr),
      .base    (tbl_base),
      .mask    (tbl_mask),
      .en      (en_vec),
      .hit_vec (hit_vec)
   );

   cs_first_hit #(
      .NUM_CS (NUM_CS),
      .IDX_W  (IDX_W),
      .STYLE  (STYLE)
   ) u_first (
      .hit_vec (hit_vec),
      .any_o   (any_hit),
      .idx_o   (first_idx)
   );

   cs_spare_map #(
      .NUM_CS (NUM_CS),
      .IDX_W  (IDX_W)
   ) u_spare (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (spr_we),
      .cfg_bad    (spr_bad),
      .cfg_target (spr_target),
      .hit_i      (any_hit),
      .idx_i      (first_idx),
      .bad_q      (spr_bad_q),
      .tgt_q      (spr_tgt_q),
      .cs_o       (final_cs),
      .moved_o    (moved),
      .fail_o     (move_fail)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_hit        <= 1'b0;
         rsp_cs         <= INV_IDX;
         rsp_redirected <= 1'b0;
         rsp_redir_err  <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_hit        <= any_hit;
            rsp_cs         <= final_cs;
            rsp_redirected <= moved;
            rsp_redir_err  <= move_fail;
         end else begin
            rsp_hit        <= 1'b0;
            rsp_cs         <= INV_IDX;
            rsp_redirected <= 1'b0;
            rsp_redir_err  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cs_resolver_chk.sv
module cs_resolver_chk #(
   parameter int NUM_CS = 8,
   parameter int IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [IDX_W-1:0]  rsp_cs,
   input logic              rsp_redirected,
   input logic              rsp_redir_err,
   input logic [NUM_CS-1:0] ent_en,
   input logic [IDX_W-1:0]  bad_q,
   input logic [IDX_W-1:0]  tgt_q
);

   localparam logic [IDX_W-1:0] INV_IDX = '1;

   logic              armed;
   logic [NUM_CS-1:0] en_prev;
   logic [IDX_W-1:0]  bad_prev;
   logic [IDX_W-1:0]  tgt_prev;
   logic              reported_on;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         en_prev  <= '0;
         bad_prev <= INV_IDX;
         tgt_prev <= INV_IDX;
      end else begin
         armed    <= 1'b1;
         en_prev  <= ent_en;
         bad_prev <= bad_q;
         tgt_prev <= tgt_q;
      end
   end

   always_comb begin
      reported_on = 1'b0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (rsp_cs == IDX_W'(i)) reported_on = en_prev[i];
      end
   end

   // R8: one-cycle response strobe
   a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (rsp_valid == $past(req_valid)));

   // R8: idle response carries no flags
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_hit && !rsp_redirected && !rsp_redir_err && rsp_cs == INV_IDX));

   // R2: an unredirected hit names an entry that was enabled
   a_r2_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit && !rsp_redirected) |-> reported_on);

   // R4: miss reports the invalid code and no spare activity
   a_r4_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_cs == INV_IDX && !rsp_redirected && !rsp_redir_err));

   // R5: redirect lands on the configured spare
   a_r5_redirect_target: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_redirected) |-> (rsp_hit && !rsp_redir_err && rsp_cs == tgt_prev));

   // R6: invalid bad number never redirects
   a_r6_no_move_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && bad_prev == INV_IDX) |-> (!rsp_redirected && !rsp_redir_err));

   // R7: failed redirect keeps the bad index and points at an absent spare
   a_r7_fail_shape: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_redir_err |-> (rsp_hit && !rsp_redirected && rsp_cs == bad_prev
                         && int'(tgt_prev) >= NUM_CS));

endmodule

bind cs_resolver cs_resolver_chk #(
   .NUM_CS (NUM_CS),
   .IDX_W  (IDX_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .rsp_valid      (rsp_valid),
   .rsp_hit        (rsp_hit),
   .rsp_cs         (rsp_cs),
   .rsp_redirected (rsp_redirected),
   .rsp_redir_err  (rsp_redir_err),
   .ent_en         (en_vec),
   .bad_q          (spr_bad_q),
   .tgt_q          (spr_tgt_q)
);

// File: tb/cs_resolver_test.sv
`timescale 1ns/1ps
module cs_resolver_test;
   import cs_resolver_pkg::*;

   localparam int N   = 5;
   localparam int AW  = 16;
   localparam int IW  = 3;
   localparam int INV = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ent_we = 1'b0;
   logic [IW-1:0] ent_idx = '0;
   logic [AW-1:0] ent_base = '0;
   logic [AW-1:0] ent_mask = '0;
   logic          ent_on = 1'b0;
   logic          spr_we = 1'b0;
   logic [IW-1:0] spr_bad = '0;
   logic [IW-1:0] spr_target = '0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid, rsp_hit, rsp_redirected, rsp_redir_err;
   logic [IW-1:0] rsp_cs;

   always #2 clk = ~clk;   // 250 MHz

   cs_resolver #(
      .NUM_CS (N),
      .ADDR_W (AW),
      .IDX_W  (IW),
      .STYLE  (SEARCH_ISOLATE)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .ent_we(ent_we), .ent_idx(ent_idx), .ent_base(ent_base),
      .ent_mask(ent_mask), .ent_on(ent_on),
      .spr_we(spr_we), .spr_bad(spr_bad), .spr_target(spr_target),
      .req_valid(req_valid), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_cs(rsp_cs),
      .rsp_redirected(rsp_redirected), .rsp_redir_err(rsp_redir_err)
   );

   // Behavioural reference state
   int m_base[N];
   int m_mask[N];
   bit m_en[N];
   int m_bad = INV;
   int m_spare = INV;

   int e_valid, e_hit, e_cs, e_redir, e_err;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic predict();
      int a;
      a = int'(req_addr);
      e_valid = int'(req_valid);
      e_hit = 0; e_cs = INV; e_redir = 0; e_err = 0;
      if (req_valid) begin
         for (int i = 0; i < N; i++) begin
            if (e_hit == 0 && m_en[i] &&
                ((a & ~m_mask[i] & 16'hFFFF) == (m_base[i] & ~m_mask[i] & 16'hFFFF))) begin
               e_hit = 1; e_cs = i;
            end
         end
         if (e_hit == 1 && e_cs == m_bad) begin
            if (m_spare < N) begin e_cs = m_spare; e_redir = 1; end
            else e_err = 1;
         end
      end
   endtask

   task automatic cycle(input string tag);
      predict();
      @(posedge clk);
      if (ent_we && int'(ent_idx) < N) begin
         m_base[ent_idx] = int'(ent_base);
         m_mask[ent_idx] = int'(ent_mask);
         m_en[ent_idx]   = ent_on;
      end
      if (spr_we) begin m_bad = int'(spr_bad); m_spare = int'(spr_target); end
      #1;
      chk(tag, "rsp_valid", int'(rsp_valid), e_valid);
      chk(tag, "rsp_hit", int'(rsp_hit), e_hit);
      chk(tag, "rsp_cs", int'(rsp_cs), e_cs);
      chk(tag, "rsp_redirected", int'(rsp_redirected), e_redir);
      chk(tag, "rsp_redir_err", int'(rsp_redir_err), e_err);
      @(negedge clk);
   endtask

   task automatic quiet();
      ent_we = 0; spr_we = 0; req_valid = 0;
   endtask

   task automatic req(input int addr, input string tag);
      quiet(); req_valid = 1; req_addr = AW'(addr);
      cycle(tag);
   endtask

   task automatic wr_ent(input int idx, input int base, input int mask, input bit on, input string tag);
      quiet(); ent_we = 1; ent_idx = IW'(idx); ent_base = AW'(base);
      ent_mask = AW'(mask); ent_on = on;
      cycle(tag);
   endtask

   task automatic wr_spr(input int bad, input int spare, input string tag);
      quiet(); spr_we = 1; spr_bad = IW'(bad); spr_target = IW'(spare);
      cycle(tag);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=expired expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_base[i] = 0; m_mask[i] = 0; m_en[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R9: reset state
      chk("R9", "rsp_valid", int'(rsp_valid), 0);
      chk("R9", "rsp_cs", int'(rsp_cs), INV);
      req(16'h1234, "R9");            // empty table misses
      req(16'h0000, "R9");

      wr_ent(0, 16'h1000, 16'h0FFF, 1, "R10");
      wr_ent(1, 16'h2000, 16'h0FFF, 1, "R10");
      wr_ent(2, 16'h2000, 16'h1FFF, 1, "R10");
      wr_ent(3, 16'h8000, 16'h00FF, 0, "R10");
      wr_ent(4, 16'hFF00, 16'h0000, 1, "R10");

      req(16'h1234, "R1");
      req(16'h3ABC, "R1");            // only entry 2 ignores bit 12
      req(16'hFF00, "R1");            // exact
      req(16'hFF01, "R1");            // exact mismatch
      req(16'h2ABC, "R3");            // 1 and 2 overlap, 1 wins
      req(16'h8012, "R2");            // disabled entry
      req(16'h5000, "R4");
      quiet(); req_valid = 0; cycle("R8");
      quiet(); cycle("R8");

      // R10: same-cycle write invisible, then visible
      quiet(); ent_we = 1; ent_idx = 3; ent_base = 16'h8000; ent_mask = 16'h00FF; ent_on = 1;
      req_valid = 1; req_addr = 16'h8012; cycle("R10");
      req(16'h8012, "R10");
      wr_ent(6, 16'h6000, 16'hFFFF, 1, "R10");   // out of range, ignored
      req(16'h6000, "R10");

      // Spare handling
      wr_spr(1, 3, "R11");
      req(16'h2ABC, "R5");
      req(16'h1234, "R6");
      quiet(); spr_we = 1; spr_bad = 0; spr_target = 4;
      req_valid = 1; req_addr = 16'h1234; cycle("R11");   // uses previous pair
      req(16'h1234, "R5");
      wr_spr(1, 6, "R11");
      req(16'h2ABC, "R7");
      wr_spr(1, 7, "R11");
      req(16'h2ABC, "R7");
      wr_spr(7, 7, "R6");
      req(16'h2ABC, "R6");
      wr_spr(7, 2, "R6");
      req(16'h3ABC, "R6");
      wr_spr(4, 0, "R5");
      req(16'hFF00, "R5");

      // Random mix
      for (int k = 0; k < 600; k++) begin
         int r;
         r = int'($urandom % 10);
         quiet();
         if (r < 2 || r == 3) begin
            ent_we = 1; ent_idx = IW'($urandom % 8);
            ent_base = AW'(($urandom % 16) << 12 | ($urandom % 4) << 8);
            case ($urandom % 4)
               0: ent_mask = 16'h0FFF;
               1: ent_mask = 16'h00FF;
               2: ent_mask = 16'h0000;
               default: ent_mask = 16'h3FFF;
            endcase
            ent_on = ($urandom % 4) != 0;
         end else if (r == 2) begin
            spr_we = 1; spr_bad = IW'($urandom % 8); spr_target = IW'($urandom % 8);
         end
         if (r >= 3) begin
            req_valid = 1;
            req_addr = AW'(($urandom % 16) << 12 | ($urandom % 4) << 8 | ($urandom % 3));
         end
         cycle("R1 R3 R5 R7 random");
      end

      done = 1;
      summary();
      $finish;
   end

endmodule